// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved branch directions. It also keeps a table of two-bit saturating counters. A lookup hashes the fetch address with that history to pick one counter. The upper bit of that counter is the guess. The lookup also returns the index it used.

The fetch stage carries the index along with the branch. When the branch resolves, the back end presents the real direction and the carried index on the training port. That counter then moves one step toward the outcome, and the outcome is shifted into the history. Training uses the carried index rather than a fresh hash, so history that has moved on since the lookup cannot train the wrong counter.

The lookup is purely combinational from the stored state. A lookup and a training write to the same counter in the same cycle therefore return the counter value from before the write.

Top module: `gsh_predictor`

## Requirements
- R1: After reset every counter holds weakly taken (binary 10) and the history is all zeros, so any lookup predicts taken and returns the address slice itself as its index.
- R2: The lookup index equals the history register XORed with address bits [ALIGN_BITS+HIST_W-1 : ALIGN_BITS] of `lkp_pc`.
- R3: `lkp_taken` is 1 exactly when the selected counter is 10 or 11 (its upper bit is set).
- R4: A training event with outcome taken raises the addressed counter by one, and it stays at 11 once it reaches 11.
- R5: A training event with outcome not taken lowers the addressed counter by one, and it stays at 00 once it reaches 00.
- R6: A counter at 11 keeps predicting taken after one not-taken outcome and flips only after the second. A counter at 00 likewise needs two taken outcomes to flip.
- R7: Each training event shifts its outcome into history bit 0, moves every bit up one place, and drops the oldest bit.
- R8: Training changes only the counter at `upd_idx`. It does not touch the counter that the current history would hash to.
- R9: When a lookup selects the counter being trained in the same cycle, it returns the value from before that training.
- R10: While `upd_valid` is 0, neither the counters nor the history change, whatever `upd_taken` and `upd_idx` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | PC_W | Fetch address of the branch being predicted |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_idx | output | HIST_W | Table index used for this lookup |
| upd_valid | input | 1 | Training event present this cycle |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_idx | input | HIST_W | Index returned when the branch was looked up |

## Verification
The in-RTL properties check two things on every cycle. First, that the history shifts correctly on each training event and holds still without one. Second, that a counter already at either end stays there when pushed further in the same direction. The bench's scenarios are the only place several behaviours show up. These are the exact hash of address and history, the two-miss hysteresis out of a strong state, the read-before-write result when lookup and training meet on one counter, and the fact that training with a stale index leaves the freshly hashed counter alone. The restoration of every counter to weakly taken by a second reset mid-run is likewise shown only by the bench.

// File: rtl/gsh_pkg.sv
package gsh_pkg;
   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'b00;
   localparam ctr_t CTR_WEAK_NT   = 2'b01;
   localparam ctr_t CTR_WEAK_T    = 2'b10;
   localparam ctr_t CTR_STRONG_T  = 2'b11;

   // one saturating step toward the resolved direction
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction
endpackage

// File: rtl/gsh_history.sv
module gsh_history #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist_q
);
   if (HIST_W < 1) begin : g_bad_width
      $error("gsh_history: HIST_W must be at least 1");
   end

   logic [HIST_W-1:0] hist_d;

   if (HIST_W == 1) begin : g_single
      always_comb hist_d = shift_en ? shift_bit : hist_q;
   end else begin : g_multi
      always_comb hist_d = shift_en ? {hist_q[HIST_W-2:0], shift_bit} : hist_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= hist_d;
   end

   // R7: newest outcome lands in bit 0
   assert_newest_in_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist_q[0] == $past(shift_bit));

   if (HIST_W > 1) begin : g_shift_chk
      assert_bits_move_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
         shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
   end

   // R10: no training, no movement
   assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/gsh_index.sv
module gsh_index #(
   parameter int HIST_W     = 8,
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [HIST_W-1:0] idx
);
   localparam int PC_AVAIL = PC_W - ALIGN_BITS;

   if (PC_AVAIL < 1) begin : g_bad_align
      $error("gsh_index: PC_W must exceed ALIGN_BITS");
   end

   logic [HIST_W-1:0] pc_part;

   if (PC_AVAIL >= HIST_W) begin : g_full_slice
      assign pc_part = pc[ALIGN_BITS +: HIST_W];
   end else begin : g_short_slice
      assign pc_part = {{(HIST_W-PC_AVAIL){1'b0}}, pc[PC_W-1:ALIGN_BITS]};
   end

   logic unused_pc_bits;
   assign unused_pc_bits = ^pc;

   assign idx = pc_part ^ hist;
endmodule

// File: rtl/gsh_table.sv
module gsh_table
   import gsh_pkg::*;
#(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken,
   input  logic              wr_en,
   input  logic              wr_taken,
   input  logic [HIST_W-1:0] wr_idx
);
   localparam int DEPTH = 1 << HIST_W;

   if (HIST_W > 12) begin : g_too_deep
      $error("gsh_table: HIST_W above 12 makes an oversized flop table");
   end

   ctr_t cnt_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_WEAK_T;
      end else if (wr_en) begin
         cnt_q[wr_idx] <= ctr_step(cnt_q[wr_idx], wr_taken);
      end
   end

   // reads see stored state only, so a same-cycle write is not visible
   assign rd_taken = cnt_q[rd_idx][1];

   // R4: taken at the top stays at the top
   assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && cnt_q[wr_idx] == CTR_STRONG_T)
      |=> cnt_q[$past(wr_idx)] == CTR_STRONG_T);

   // R5: not taken at the bottom stays at the bottom
   assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && cnt_q[wr_idx] == CTR_STRONG_NT)
      |=> cnt_q[$past(wr_idx)] == CTR_STRONG_NT);
endmodule

// File: rtl/gsh_predictor.sv
module gsh_predictor #(
   parameter int HIST_W     = 8,
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   lkp_pc,
   output logic              lkp_taken,
   output logic [HIST_W-1:0] lkp_idx,
   input  logic              upd_valid,
   input  logic              upd_taken,
   input  logic [HIST_W-1:0] upd_idx
);
   logic [HIST_W-1:0] hist;

   gsh_history #(.HIST_W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .shift_en(upd_valid), .shift_bit(upd_taken),
      .hist_q(hist)
   );

   gsh_index #(.HIST_W(HIST_W), .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) u_idx (
      .pc(lkp_pc), .hist(hist), .idx(lkp_idx)
   );

   gsh_table #(.HIST_W(HIST_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lkp_idx), .rd_taken(lkp_taken),
      .wr_en(upd_valid), .wr_taken(upd_taken), .wr_idx(upd_idx)
   );
endmodule

// File: tb/sim_gsh_predictor.sv
module sim_gsh_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lkp_pc = '0;
   logic        lkp_taken;
   logic [7:0]  lkp_idx;
   logic        upd_valid = 1'b0;
   logic        upd_taken = 1'b0;
   logic [7:0]  upd_idx = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   gsh_predictor u0 (
      .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc),
      .lkp_taken(lkp_taken), .lkp_idx(lkp_idx),
      .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_idx(upd_idx)
   );

   // {uv, ut, uidx[8], pc[16], exp_taken, exp_idx[8]}; check is taken before the row's edge
   localparam int NV = 14;
   localparam logic [34:0] VEC [NV] = '{
      {1'b0,1'b0,8'h00,16'h0010,1'b1,8'h04},  // R1 fresh entry
      {1'b1,1'b0,8'h04,16'h0010,1'b1,8'h04},  // R9 old value seen
      {1'b1,1'b0,8'h04,16'h0010,1'b0,8'h04},  // R5 down to 01
      {1'b1,1'b0,8'h04,16'h0010,1'b0,8'h04},  // R5 at 00
      {1'b1,1'b1,8'h04,16'h0010,1'b0,8'h04},  // R5 saturated, R6
      {1'b0,1'b0,8'h00,16'h0014,1'b0,8'h04},  // R2 hist 01
      {1'b1,1'b1,8'h04,16'h0014,1'b0,8'h04},  // R6 still not taken
      {1'b0,1'b0,8'h00,16'h001C,1'b1,8'h04},  // R6 flipped, R3
      {1'b1,1'b1,8'h04,16'h0000,1'b1,8'h03},  // R7 hist 03
      {1'b1,1'b1,8'h04,16'h0000,1'b1,8'h07},  // R4 to 11
      {1'b1,1'b0,8'h04,16'h003C,1'b1,8'h00},  // R4 saturated then down
      {1'b0,1'b0,8'h00,16'h0068,1'b1,8'h04},  // R6 one miss keeps taken
      {1'b1,1'b0,8'h04,16'h0068,1'b1,8'h04},  // R6 second miss
      {1'b0,1'b0,8'h00,16'h00E0,1'b0,8'h04}   // R6 flipped after two
   };

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got taken=%0b idx=%02h, expected taken=%0b idx=%02h",
                  req, act[8], act[7:0], exp[8], exp[7:0]);
      end
   endtask

   task automatic step(input logic uv, input logic ut, input logic [7:0] ui,
                       input logic [31:0] pc, input string req,
                       input logic et, input logic [7:0] ei);
      @(negedge clk);
      upd_valid = uv; upd_taken = ut; upd_idx = ui; lkp_pc = pc;
      #1 check(req, {lkp_taken, lkp_idx}, {et, ei});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; upd_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got running, expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state, address slice 0xAF
      step(0, 0, 8'h00, 32'h0000_0ABC, "R1", 1'b1, 8'hAF);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][34], VEC[i][33], VEC[i][32:25], {16'h0, VEC[i][24:9]},
              $sformatf("vec%0d R2/R3", i), VEC[i][8], VEC[i][7:0]);
      end

      // R10: junk on training inputs without valid changes nothing
      step(0, 1, 8'h04, 32'h0000_00E0, "R10", 1'b0, 8'h04);
      step(0, 1, 8'h38, 32'h0000_00E0, "R10", 1'b0, 8'h04);
      step(0, 0, 8'h04, 32'h0000_00E0, "R10", 1'b0, 8'h04);

      // R1: second reset restores weakly taken and clears history
      do_reset();
      step(0, 0, 8'h00, 32'h0000_0010, "R1", 1'b1, 8'h04);

      // R8: train index 55 with a lookup hashing elsewhere
      step(1, 0, 8'h55, 32'h0000_0150, "R8", 1'b1, 8'h54);
      step(1, 0, 8'h55, 32'h0000_0150, "R8", 1'b1, 8'h54);
      step(0, 0, 8'h00, 32'h0000_0154, "R8", 1'b0, 8'h55);
      step(0, 0, 8'h00, 32'h0000_0150, "R8", 1'b1, 8'h54);

      // R7: nine taken outcomes fill history, oldest drops out
      do_reset();
      for (int k = 0; k < 9; k++) step(1, 1, 8'h00, 32'h0, "R7", 1'b1, 8'h00 | ((8'h01 << k) - 8'h01));
      step(1, 0, 8'h00, 32'h0, "R7", 1'b1, 8'hFF);
      step(0, 0, 8'h00, 32'h0, "R7", 1'b1, 8'hFE);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule